// File: doc/BRIEF.md
# Size-Selectable Add/Subtract Unit with Status Flags

This block adds or subtracts two operands at 8-, 16- or 32-bit width and records six status flags for the result. A narrow operation uses the low byte or low half of each 32-bit input. Any bits above the chosen width are masked off before the arithmetic. The result is zero-extended to 32 bits.

A caller drives both operands, the operation and the size, and pulses `valid_i` for one cycle. The result and the flags are registered and appear one clock after the strobe. They then hold until the next strobe, so software-visible state is readable at any time. Reset clears both.

Flags come from the selected width. Carry and overflow track the unsigned and signed range of that width. Sign is the top bit at that width, and zero tests the masked result. The auxiliary flag looks at the nibble boundary, and parity always inspects the low byte only.

Top module: `szarith_unit`

## Requirements
- R1: With `op_i` = 0 (add) and a valid strobe, `result_o` becomes (a + b) modulo 2^W, zero-extended, where W is 8, 16 or 32 for `size_i` = 00, 01, 10, and 11 also selects 32.
- R2: With `op_i` = 1 (subtract), `result_o` becomes (a - b) modulo 2^W, zero-extended.
- R3: Carry, `flags_o[0]`, is the carry out of bit W-1 for add, and for subtract it is set exactly when a < b as unsigned W-bit numbers.
- R4: Overflow, `flags_o[5]`, is set when the signed W-bit result is out of range: for add, when the operand signs match and the result sign differs; for subtract, when the operand signs differ and the result sign differs from a's sign.
- R5: Sign, `flags_o[4]`, equals bit W-1 of the result.
- R6: Zero, `flags_o[3]`, is set exactly when the W-bit result is all zeros.
- R7: Auxiliary carry, `flags_o[2]`, is set on a carry from bit 3 into bit 4 for add, and for subtract when a[3:0] < b[3:0] (a borrow into bit 4).
- R8: Parity, `flags_o[1]`, is set when `result_o[7:0]` holds an even number of 1 bits, at every size.
- R9: Operand bits at and above W have no effect on the result or the flags, and `result_o` bits at and above W are 0.
- R10: `result_o` and `flags_o` change only on the clock edge that samples `valid_i` = 1. In every other cycle they hold their value, whatever the other inputs do.
- R11: While reset is asserted, `result_o` and `flags_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| valid_i | input | 1 | One-cycle operation strobe |
| op_i | input | 1 | 0 add, 1 subtract |
| size_i | input | 2 | 00 byte, 01 halfword, 10 or 11 word |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| result_o | output | 32 | Registered, zero-extended result |
| flags_o | output | 6 | {overflow, sign, zero, aux, parity, carry} |

## Verification
The byte width is swept over every first operand against a strided set of second operands, in both directions. These cases separate carry from overflow, split nibble carries from byte carries, and show borrow against wrap. Halfword and word runs cross a corner set around 0, ±1, the nibble edge and the sign boundary, so a flag taken at the wrong width shows up. Pseudo-random operations mix all sizes with garbage in the upper operand bits to test masking. Idle cycles with changing inputs, and a reset between operations, show that the registers hold and clear.

// File: rtl/szarith_pkg.sv
package szarith_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned NIB_W     = 4;
  localparam int unsigned NUM_SIZES = 3;
  localparam int unsigned FLAG_W    = 6;

  typedef enum logic {OP_ADD = 1'b0, OP_SUB = 1'b1} op_e;

  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
    logic aux;
    logic par;
    logic cry;
  } flags_t;

  // Width index: 0 byte, 1 halfword, 2 word (codes 10 and 11)
  function automatic int size_index(input logic [1:0] code);
    case (code)
      2'b00:   size_index = 0;
      2'b01:   size_index = 1;
      default: size_index = 2;
    endcase
  endfunction
endpackage

// File: rtl/szarith_rst_sync.sv
module szarith_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) chain_q <= '0;
    else          chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/szarith_operand_prep.sv
module szarith_operand_prep
  import szarith_pkg::*;
#(
  parameter int unsigned W   = WORD_W,
  parameter int unsigned NSZ = NUM_SIZES
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  op_e            op_i,
  input  logic [NSZ-1:0] size_sel_i,
  output logic [W-1:0]   a_m_o,
  output logic [W-1:0]   bx_o,
  output logic [W-1:0]   mask_o,
  output logic           cin_o
);
  logic [NSZ-1:0][W-1:0] mask_tab;

  for (genvar g = 0; g < NSZ; g++) begin : g_mask
    assign mask_tab[g] = W'((64'd1 << (BYTE_W << g)) - 64'd1);
  end

  always_comb begin
    mask_o = '0;
    for (int k = 0; k < NSZ; k++) begin
      if (size_sel_i[k]) mask_o = mask_o | mask_tab[k];
    end
    a_m_o = a_i & mask_o;
    bx_o  = (op_i == OP_SUB) ? (~b_i & mask_o) : (b_i & mask_o);
    cin_o = (op_i == OP_SUB);
  end
endmodule

// File: rtl/szarith_adder.sv
module szarith_adder
  import szarith_pkg::*;
#(
  parameter int unsigned W   = WORD_W,
  parameter int unsigned NSZ = NUM_SIZES
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   bx_i,
  input  logic           cin_i,
  input  logic [NSZ-1:0] size_sel_i,
  output logic [W-1:0]   sum_o,
  output logic           cout_o,
  output logic           msb_r_o,
  output logic           msb_a_o,
  output logic           msb_b_o
);
  logic [W:0]     full;
  logic [NSZ-1:0] cout_tab, msbr_tab, msba_tab, msbb_tab;

  assign full  = {1'b0, a_i} + {1'b0, bx_i} + {{W{1'b0}}, cin_i};
  assign sum_o = full[W-1:0];

  for (genvar g = 0; g < NSZ; g++) begin : g_width
    localparam int unsigned SW = BYTE_W << g;
    assign cout_tab[g] = full[SW];
    assign msbr_tab[g] = full[SW-1];
    assign msba_tab[g] = a_i[SW-1];
    assign msbb_tab[g] = bx_i[SW-1];
  end

  always_comb begin
    cout_o  = |(cout_tab & size_sel_i);
    msb_r_o = |(msbr_tab & size_sel_i);
    msb_a_o = |(msba_tab & size_sel_i);
    msb_b_o = |(msbb_tab & size_sel_i);
  end
endmodule

// File: rtl/szarith_flag_eval.sv
module szarith_flag_eval
  import szarith_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic [W-1:0] sum_i,
  input  logic [W-1:0] mask_i,
  input  logic         sub_i,
  input  logic         cout_i,
  input  logic         msb_r_i,
  input  logic         msb_a_i,
  input  logic         msb_b_i,
  input  logic         a_nib_i,
  input  logic         bx_nib_i,
  output logic [W-1:0] res_o,
  output flags_t       flags_o
);
  always_comb begin
    res_o       = sum_i & mask_i;
    flags_o.cry = cout_i ^ sub_i;
    flags_o.ovf = (msb_a_i == msb_b_i) && (msb_r_i != msb_a_i);
    flags_o.sgn = msb_r_i;
    flags_o.zro = ~|res_o;
    flags_o.par = ~^res_o[BYTE_W-1:0];
    // carry into the nibble boundary, inverted to a borrow for subtract
    flags_o.aux = a_nib_i ^ bx_nib_i ^ sum_i[NIB_W] ^ sub_i;
  end
endmodule

// File: rtl/szarith_unit.sv
module szarith_unit
  import szarith_pkg::*;
#(
  parameter int unsigned W   = WORD_W,
  parameter int unsigned NSZ = NUM_SIZES,
  parameter int unsigned FW  = FLAG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid_i,
  input  logic          op_i,
  input  logic [1:0]    size_i,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  output logic [W-1:0]  result_o,
  output logic [FW-1:0] flags_o
);
  logic           rst_sync_n;
  logic [NSZ-1:0] size_sel;
  op_e            op_sel;
  logic [W-1:0]   a_m, bx, mask, sum, res_n;
  logic           cin, cout, msb_r, msb_a, msb_b;
  flags_t         flg_n, flg_d, flg_q;
  logic [W-1:0]   res_d, res_q;

  szarith_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_sync_n)
  );

  assign op_sel = op_e'(op_i);

  for (genvar k = 0; k < NSZ; k++) begin : g_sel
    assign size_sel[k] = (size_index(size_i) == k);
  end

  szarith_operand_prep #(.W(W), .NSZ(NSZ)) u_prep (
    .a_i(a_i), .b_i(b_i), .op_i(op_sel), .size_sel_i(size_sel),
    .a_m_o(a_m), .bx_o(bx), .mask_o(mask), .cin_o(cin)
  );

  szarith_adder #(.W(W), .NSZ(NSZ)) u_add (
    .a_i(a_m), .bx_i(bx), .cin_i(cin), .size_sel_i(size_sel),
    .sum_o(sum), .cout_o(cout), .msb_r_o(msb_r), .msb_a_o(msb_a), .msb_b_o(msb_b)
  );

  szarith_flag_eval #(.W(W)) u_flag (
    .sum_i(sum), .mask_i(mask), .sub_i(cin), .cout_i(cout),
    .msb_r_i(msb_r), .msb_a_i(msb_a), .msb_b_i(msb_b),
    .a_nib_i(a_m[NIB_W]), .bx_nib_i(bx[NIB_W]),
    .res_o(res_n), .flags_o(flg_n)
  );

  always_comb begin
    res_d = res_q;
    flg_d = flg_q;
    if (valid_i) begin
      res_d = res_n;
      flg_d = flg_n;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_q <= '0;
      flg_q <= '0;
    end else begin
      res_q <= res_d;
      flg_q <= flg_d;
    end
  end

  assign result_o = res_q;
  assign flags_o  = FW'(flg_q);
endmodule

// File: rtl/szarith_checker.sv
module szarith_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        valid_i,
  input logic        op_i,
  input logic [1:0]  size_i,
  input logic [31:0] a_i,
  input logic [31:0] b_i,
  input logic [31:0] result_o,
  input logic [5:0]  flags_o
);
  logic       any_op;
  logic [1:0] last_size;
  logic       top_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      any_op    <= 1'b0;
      last_size <= 2'b00;
    end else if (valid_i) begin
      any_op    <= 1'b1;
      last_size <= size_i;
    end
  end

  always_comb begin
    case (last_size)
      2'b00:   top_bit = result_o[7];
      2'b01:   top_bit = result_o[15];
      default: top_bit = result_o[31];
    endcase
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> ($stable(result_o) && $stable(flags_o)));

  assert_word_add_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !op_i && size_i == 2'b10) |=> (result_o == $past(a_i + b_i)));

  assert_borrow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i && size_i[1] && (a_i < b_i)) |=> flags_o[0]);

  assert_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
    any_op |-> (flags_o[4] == top_bit));

  assert_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    any_op |-> (flags_o[3] == (result_o == 32'd0)));

  assert_parity_R8: assert property (@(posedge clk) disable iff (!rst_n)
    any_op |-> (flags_o[1] == ~^result_o[7:0]));

  assert_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (any_op && !last_size[1]) |-> (result_o[31:16] == 16'd0));
endmodule

bind szarith_unit szarith_checker u_chk (
  .clk(clk), .rst_n(rst_sync_n), .valid_i(valid_i), .op_i(op_i),
  .size_i(size_i), .a_i(a_i), .b_i(b_i), .result_o(result_o), .flags_o(flags_o)
);

// File: tb/szarith_unit_tb.sv
`timescale 1ns/1ps
module szarith_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic        op_i = 1'b0;
  logic [1:0]  size_i = 2'b00;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic [31:0] result_o;
  logic [5:0]  flags_o;

  int checks = 0;
  int failures = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  szarith_unit dut_i (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i), .size_i(size_i),
    .a_i(a_i), .b_i(b_i), .result_o(result_o), .flags_o(flags_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model(input logic op, input logic [1:0] sz, input logic [31:0] a,
                       input logic [31:0] b, output logic [31:0] r, output logic [5:0] f);
    int w;
    logic [32:0] m33, s33;
    logic [31:0] am, bm;
    logic cf, of, sf, zf, af, pf, sa, sb;
    w   = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
    m33 = (33'd1 << w) - 33'd1;
    am  = a & m33[31:0];
    bm  = b & m33[31:0];
    if (!op) begin
      s33 = {1'b0, am} + {1'b0, bm};
      r   = s33[31:0] & m33[31:0];
      cf  = s33[w];
      af  = ({1'b0, am[3:0]} + {1'b0, bm[3:0]}) > 5'd15;
    end else begin
      r   = (am - bm) & m33[31:0];
      cf  = am < bm;
      af  = am[3:0] < bm[3:0];
    end
    sa = am[w-1];
    sb = bm[w-1];
    sf = r[w-1];
    of = op ? ((sa != sb) && (sf != sa)) : ((sa == sb) && (sf != sa));
    zf = (r == 32'd0);
    pf = ~^r[7:0];
    f  = {of, sf, zf, af, pf, cf};
  endtask

  // Drive at a falling edge, let one rising edge sample it, check at the next falling edge.
  task automatic run_op(input logic op, input logic [1:0] sz, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] er;
    logic [5:0]  ef;
    valid_i = 1'b1; op_i = op; size_i = sz; a_i = a; b_i = b;
    @(posedge clk);
    @(negedge clk);
    valid_i = 1'b0;
    model(op, sz, a, b, er, ef);
    chk(op ? "R2 R9 result" : "R1 R9 result", result_o, er);
    chk("R3 carry",    {31'd0, flags_o[0]}, {31'd0, ef[0]});
    chk("R8 parity",   {31'd0, flags_o[1]}, {31'd0, ef[1]});
    chk("R7 aux",      {31'd0, flags_o[2]}, {31'd0, ef[2]});
    chk("R6 zero",     {31'd0, flags_o[3]}, {31'd0, ef[3]});
    chk("R5 sign",     {31'd0, flags_o[4]}, {31'd0, ef[4]});
    chk("R4 overflow", {31'd0, flags_o[5]}, {31'd0, ef[5]});
  endtask

  function automatic logic [31:0] corner(input int i, input logic [1:0] sz);
    logic [31:0] v;
    case (i)
      0: v = 32'h0;        1: v = 32'h1;        2: v = 32'h7;        3: v = 32'h8;
      4: v = 32'hF;        5: v = 32'h10;       6: v = 32'h7FFF;     7: v = 32'h8000;
      8: v = 32'h8001;     9: v = 32'hFFFF;     10: v = 32'h7FFF_FFFF; 11: v = 32'h8000_0000;
      12: v = 32'hFFFF_FFFF; 13: v = 32'h1234_5678; 14: v = 32'hFFFF_FFFE; default: v = 32'h0001_0000;
    endcase
    if (sz == 2'b01) v = {16'hBEEF ^ v[31:16], v[15:0]}; // garbage above the halfword
    return v;
  endfunction

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [31:0] hr, ar, br;
    logic [5:0]  hf;
    repeat (3) @(negedge clk);
    chk("R11 result in reset", result_o, 32'd0);
    chk("R11 flags in reset", {26'd0, flags_o}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 result after reset", result_o, 32'd0);
    chk("R11 flags after reset", {26'd0, flags_o}, 32'd0);

    // Byte: every a, strided b, both directions, garbage in upper bits (R9)
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b += 5) begin
        for (int op = 0; op < 2; op++) begin
          run_op(op[0], 2'b00,
                 {24'hC3A596 ^ {3{b[7:0]}}, a[7:0]},
                 {24'h5A0F69 ^ {3{a[7:0]}}, b[7:0]});
        end
      end
    end

    // Halfword and word corners; code 11 also means word (R9)
    for (int sz = 1; sz < 4; sz++) begin
      for (int i = 0; i < 16; i++) begin
        for (int j = 0; j < 16; j++) begin
          run_op(1'b0, sz[1:0], corner(i, sz[1:0]), corner(j, sz[1:0]));
          run_op(1'b1, sz[1:0], corner(i, sz[1:0]), corner(j, sz[1:0]));
        end
      end
    end

    // Pseudo-random mixed sizes
    for (int n = 0; n < 4000; n++) begin
      seed = seed * 32'd1664525 + 32'd1013904223; ar = seed;
      seed = seed * 32'd1664525 + 32'd1013904223; br = seed;
      run_op(seed[7], seed[13:12], ar, br);
    end

    // Hold: idle cycles with changing inputs leave the outputs alone (R10)
    run_op(1'b1, 2'b01, 32'h0000_0003, 32'h0000_0005);
    hr = result_o; hf = flags_o;
    for (int c = 0; c < 6; c++) begin
      op_i = c[0]; size_i = c[1:0]; a_i = 32'hFFFF_0000 >> c; b_i = 32'h0F0F_1234 << c;
      @(negedge clk);
      chk("R10 result hold", result_o, hr);
      chk("R10 flags hold", {26'd0, flags_o}, {26'd0, hf});
    end

    // Reset between operations clears state (R11)
    run_op(1'b0, 2'b10, 32'hFFFF_FFFF, 32'h0000_0001);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11 result cleared", result_o, 32'd0);
    chk("R11 flags cleared", {26'd0, flags_o}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_op(1'b0, 2'b00, 32'h0000_0080, 32'h0000_0080);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule